// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in-first-out buffer for streaming data. It has an 18-bit write port and an 18-bit read port. Each port runs on its own free-running clock and has its own active-low enable. A word is stored on a rising write-clock edge. It comes out on a rising read-clock edge, in the order it was written. The write and read pointers cross between the two clock domains as Gray codes through synchronizer chains. The depth is a power of two from 256 to 4096 words.

Five active-low status flags report the fill level. Full, half-full and almost-full are built in the write domain. Empty and almost-empty are built in the read domain. The two almost thresholds are held in offset registers. Software loads them through the write port while a load strobe is held low.

An active-low output enable selects how a read behaves:
- **Output enabled:** the read registers the word and drives it onto the read bus.
- **Output disabled:** the bus is released to high impedance. A read in this state still consumes the word, so words can be skipped.

An active-low asynchronous reset empties the FIFO and restores the default offsets.

Top module: `dcf_fifo`

## Requirements
- R1: After reset is released, empty_n and aempty_n are 0, and full_n, half_n and afull_n are 1. Both offsets hold 7.
- R2: Words read with oe_n low appear on rd_data in write order. Each word is valid after the rd_clk edge at which rd_en_n was sampled low.
- R3: empty_n is 0 exactly when the FIFO holds no word. A read while empty is ignored: the next word written is the next word read.
- R4: full_n is 0 exactly when DEPTH words are held. A write while full is ignored and stores nothing.
- R5: half_n is 0 exactly when the occupancy exceeds DEPTH/2.
- R6: aempty_n is 0 exactly when the occupancy is less than or equal to the almost-empty offset.
- R7: afull_n is 0 exactly when the occupancy is greater than or equal to DEPTH minus the almost-full offset.
- R8: A write-clock edge with ld_n and wr_en_n both low loads an offset instead of storing data. The offset is taken from wr_data bits [log2(DEPTH)-1:0]. The loads alternate, starting with the almost-empty offset after reset, then the almost-full offset.
- R9: A read with oe_n high removes the word without updating the read data register. The next read returns the following word.
- R10: Each pointer moves by at most one Gray-code bit per edge. A flag computed in the opposite domain reflects a change within four edges of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Active-low write enable |
| ld_n | input | 1 | Active-low offset load select |
| wr_data | input | 18 | Write data; low bits carry offsets during a load |
| full_n | output | 1 | Active-low full flag (write domain) |
| half_n | output | 1 | Active-low half-full flag (write domain) |
| afull_n | output | 1 | Active-low almost-full flag (write domain) |
| rd_clk | input | 1 | Read clock |
| rd_en_n | input | 1 | Active-low read enable |
| oe_n | input | 1 | Active-low output enable; high releases rd_data |
| rd_data | output | 18 | Read data, high impedance while oe_n is high |
| empty_n | output | 1 | Active-low empty flag (read domain) |
| aempty_n | output | 1 | Active-low almost-empty flag (read domain) |

## Verification
Timing of each result:
- Read data changes at the read-clock edge that samples rd_en_n low. The bench samples it half a read cycle later.
- A flag computed in the same domain as the stimulus changes right after that domain's edge.
- A flag computed in the opposite domain needs up to three edges of its own clock: the Gray pointer register, then two synchronizer flops.

The bench therefore checks every flag only after six idle cycles of both clocks. It compares read data on the negative edge that follows each read.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   localparam int PTR_MAX   = 13;
   localparam int DEF_OFS   = 7;
   localparam int MIN_DEPTH = 256;
   localparam int MAX_DEPTH = 4096;

   typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} ofs_sel_e;

   function automatic logic [PTR_MAX-1:0] gray2bin(input logic [PTR_MAX-1:0] g);
      logic [PTR_MAX-1:0] b;
      b[PTR_MAX-1] = g[PTR_MAX-1];
      for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction
endpackage

// File: rtl/dcf_ptr.sv
module dcf_ptr #(
   parameter int AW = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        inc,
   output logic [AW:0] bin,
   output logic [AW:0] gray
);
   logic [AW:0] bin_nx;

   assign bin_nx = bin + (AW+1)'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin  <= '0;
         gray <= '0;
      end else begin
         bin  <= bin_nx;
         gray <= (bin_nx >> 1) ^ bin_nx;
      end
   end
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else if (s == 0) stg[s] <= d;
            else stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
   parameter int DW = 18,
   parameter int AW = 8
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int WORDS = 1 << AW;

   logic [DW-1:0] cells [WORDS];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else if (re) rdata <= cells[raddr];
   end
endmodule

// File: rtl/dcf_ofs.sv
module dcf_ofs
   import dcf_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [AW-1:0] d,
   output logic [AW-1:0] ae_ofs,
   output logic [AW-1:0] af_ofs
);
   ofs_sel_e sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel    <= SEL_AE;
         ae_ofs <= AW'(DEF_OFS);
         af_ofs <= AW'(DEF_OFS);
      end else if (ld) begin
         if (sel == SEL_AE) begin
            ae_ofs <= d;
            sel    <= SEL_AF;
         end else begin
            af_ofs <= d;
            sel    <= SEL_AE;
         end
      end
   end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
   import dcf_pkg::*;
#(
   parameter int DW          = 18,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic          rst_n,
   input  logic          wr_clk,
   input  logic          wr_en_n,
   input  logic          ld_n,
   input  logic [DW-1:0] wr_data,
   output logic          full_n,
   output logic          half_n,
   output logic          afull_n,
   input  logic          rd_clk,
   input  logic          rd_en_n,
   input  logic          oe_n,
   output logic [DW-1:0] rd_data,
   output logic          empty_n,
   output logic          aempty_n
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [AW:0] DEPTH_V = PW'(DEPTH);
   localparam logic [AW:0] HALF_V  = PW'(DEPTH / 2);

   initial begin : prm_chk
      assert ((1 << AW) == DEPTH && DEPTH >= MIN_DEPTH && DEPTH <= MAX_DEPTH)
         else $error("dcf_fifo: DEPTH must be a power of two in range");
      assert (DW >= AW) else $error("dcf_fifo: DW too narrow for offsets");
      assert (SYNC_STAGES >= 2) else $error("dcf_fifo: need two sync stages");
   end

   // write domain
   logic          wr_fire, ld_fire, full_w;
   logic [AW:0]   wbin, wgray, rgray_w, rbin_w, wcnt;
   logic [AW-1:0] ae_ofs, af_ofs;

   // read domain
   logic          rd_fire, show, empty_r;
   logic [AW:0]   rbin, rgray, wgray_r, wbin_r, rcnt;
   logic [DW-1:0] q;

   assign ld_fire = !wr_en_n && !ld_n;
   assign wr_fire = !wr_en_n && ld_n && !full_w;

   dcf_ptr #(.AW(AW)) u_wptr (
      .clk(wr_clk), .rst_n(rst_n), .inc(wr_fire), .bin(wbin), .gray(wgray));

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w));

   dcf_ofs #(.AW(AW)) u_ofs (
      .clk(wr_clk), .rst_n(rst_n), .ld(ld_fire), .d(wr_data[AW-1:0]),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs));

   always_comb begin
      rbin_w = PW'(gray2bin(PTR_MAX'(rgray_w)));
      wcnt   = wbin - rbin_w;
      full_w = (wcnt == DEPTH_V);
   end

   assign full_n  = !full_w;
   assign half_n  = !(wcnt > HALF_V);
   assign afull_n = !(wcnt >= (DEPTH_V - {1'b0, af_ofs}));

   assign rd_fire = !rd_en_n && !empty_r;
   assign show    = rd_fire && !oe_n;

   dcf_ptr #(.AW(AW)) u_rptr (
      .clk(rd_clk), .rst_n(rst_n), .inc(rd_fire), .bin(rbin), .gray(rgray));

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

   always_comb begin
      wbin_r  = PW'(gray2bin(PTR_MAX'(wgray_r)));
      rcnt    = wbin_r - rbin;
      empty_r = (rcnt == '0);
   end

   // the offsets are quasi-static: loaded only while traffic is idle
   assign empty_n  = !empty_r;
   assign aempty_n = !(rcnt <= {1'b0, ae_ofs});

   dcf_ram #(.DW(DW), .AW(AW)) u_ram (
      .wclk(wr_clk), .we(wr_fire), .waddr(wbin[AW-1:0]), .wdata(wr_data),
      .rclk(rd_clk), .rst_n(rst_n), .re(show), .raddr(rbin[AW-1:0]), .rdata(q));

   assign rd_data = oe_n ? {DW{1'bz}} : q;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
   parameter int DW = 18,
   parameter int AW = 8
) (
   input logic          rst_n,
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          wr_en_n,
   input logic          ld_n,
   input logic          rd_en_n,
   input logic          oe_n,
   input logic          full_n,
   input logic          half_n,
   input logic          afull_n,
   input logic          empty_n,
   input logic          aempty_n,
   input logic [AW:0]   wbin,
   input logic [AW:0]   rbin,
   input logic [AW:0]   wgray,
   input logic [AW:0]   rgray,
   input logic [DW-1:0] q
);
   // R4
   no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |=> $stable(wbin));
   // R3
   no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |=> $stable(rbin));
   // R8
   load_no_store_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!ld_n && !wr_en_n) |=> $stable(wbin));
   // R9
   skip_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!rd_en_n && oe_n) |=> $stable(q));
   // R5
   full_implies_half_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> (!half_n && !afull_n));
   // R6
   empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);
   // R10
   wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $onehot0(wgray ^ $past(wgray)));
   // R10
   rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $onehot0(rgray ^ $past(rgray)));
endmodule

bind dcf_fifo dcf_chk #(.DW(DW), .AW(AW)) u_chk (
   .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_en_n(wr_en_n),
   .ld_n(ld_n), .rd_en_n(rd_en_n), .oe_n(oe_n), .full_n(full_n),
   .half_n(half_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
   .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray), .q(q));

// File: tb/tb_dcf_fifo.sv
`timescale 1ns/1ps
module tb_dcf_fifo;
   localparam int D = 256;

   logic rst_n = 0, wr_clk = 0, rd_clk = 0;
   logic wr_en_n = 1, ld_n = 1, rd_en_n = 1, oe_n = 0;
   logic [17:0] wr_data = '0;
   logic [17:0] rd_data;
   logic full_n, half_n, afull_n, empty_n, aempty_n;

   int n_chk = 0, n_bad = 0, ae = 7, af = 7;
   logic [17:0] mdl [$];
   logic [17:0] shown = '0;
   bit done = 0;

   always #4 wr_clk = ~wr_clk;
   initial begin #3; forever #4 rd_clk = ~rd_clk; end

   dcf_fifo dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [17:0] d);
      @(negedge wr_clk); wr_en_n = 0; wr_data = d;
      @(negedge wr_clk); wr_en_n = 1;
      if (mdl.size() < D) mdl.push_back(d);
   endtask

   task automatic load(input logic [17:0] d);
      @(negedge wr_clk); wr_en_n = 0; ld_n = 0; wr_data = d;
      @(negedge wr_clk); wr_en_n = 1; ld_n = 1;
   endtask

   task automatic pop(input bit skip);
      @(negedge rd_clk); rd_en_n = 0; oe_n = skip;
      @(negedge rd_clk); rd_en_n = 1; oe_n = 0;
      #1;
      if (mdl.size() == 0) begin
         chk("R3 empty read holds data", rd_data, shown);
      end else if (skip) begin
         void'(mdl.pop_front());
         chk("R9 skip holds register", rd_data, shown);
      end else begin
         shown = mdl.pop_front();
         chk("R2 read order", rd_data, shown);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge wr_clk);
      repeat (6) @(negedge rd_clk);
   endtask

   // R10: flags checked after the crossing settles
   task automatic flags();
      int n = mdl.size();
      settle();
      chk("R3 empty_n", empty_n, n != 0);
      chk("R4 full_n", full_n, n != D);
      chk("R5 half_n", half_n, !(n > D/2));
      chk("R6 aempty_n", aempty_n, !(n <= ae));
      chk("R7 afull_n", afull_n, !(n >= D - af));
   endtask

   task automatic fill_to(input int n);
      while (mdl.size() < n) push(18'($urandom));
      flags();
   endtask

   task automatic drain_to(input int n);
      while (mdl.size() > n) pop(($urandom % 4) == 0);
      flags();
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge wr_clk);
      rst_n = 1;
      settle();
      // R1 reset state
      chk("R1 empty_n", empty_n, 0);
      chk("R1 aempty_n", aempty_n, 0);
      chk("R1 full_n", full_n, 1);
      chk("R1 half_n", half_n, 1);
      chk("R1 afull_n", afull_n, 1);
      // R1 default offsets through the almost flags
      fill_to(7); fill_to(8);
      fill_to(128); fill_to(129);
      fill_to(248); fill_to(249);
      fill_to(D);
      // R4 write while full is ignored
      push(18'h2AAAA); push(18'h15555);
      flags();
      drain_to(200); drain_to(0);
      // R3 read while empty is ignored
      pop(0); pop(0); pop(0);
      push(18'h0BEEF);
      flags();
      pop(0);
      chk("R3 next word after empty reads", rd_data, 18'h0BEEF);
      // R9 skip then next word
      push(18'h00111); push(18'h00222); push(18'h00333);
      settle();
      pop(0); pop(1); pop(0);
      chk("R9 word after skip", rd_data, 18'h00333);
      flags();
      // R8 load offsets; upper bits ignored
      load(18'h3FF04); ae = 4;
      load(18'h3FF0A); af = 10;
      flags();
      chk("R8 load stores no data", empty_n, 0);
      fill_to(4); fill_to(5);
      fill_to(245); fill_to(246);
      fill_to(D);
      drain_to(130); drain_to(5); drain_to(4); drain_to(0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge wr_clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule